// File: doc/BRIEF.md
# Mode-Selected Four-Bit ALU Slice

A combinational arithmetic/logic slice that takes two operand nibbles, a four-bit function code and a mode bit. It produces one of 32 results: sixteen arithmetic functions when the mode bit is low and sixteen bitwise Boolean functions when it is high. The slice holds no state. Its output depends only on its present inputs.

In arithmetic mode the slice picks two internal addends from the operands according to the function code. It then adds them with the carry-in through a carry-lookahead network. Each arithmetic function therefore has the form "first addend plus second addend plus carry-in". The slice also exports a group-generate and a group-propagate bit, so that an external lookahead unit can combine several slices into a wide word without carry rippling between slices. The slice width is a parameter, with a default of four bits.

In logic mode the carry network is switched off. Carry-out and both group bits are held low, and carry-in has no effect on the result.

Top module: `alu_slice`

## Requirements
- R1: With logic_mode=1 the result is, by func_sel value: 0 NOT A, 1 NOT(A OR B), 2 (NOT A) AND B, 3 all zeros, 4 NOT(A AND B), 5 NOT B, 6 A XOR B, 7 A AND NOT B, 8 (NOT A) OR B, 9 NOT(A XOR B), 10 B, 11 A AND B, 12 A, 13 A OR NOT B, 14 A OR B, 15 all ones.
- R2: With logic_mode=1, carry_out is 0 and carry_in has no effect on the result.
- R3: With logic_mode=0 the result is (X + Y + carry_in) mod 2^W. X is chosen by func_sel[1:0]: 0 A, 1 A OR B, 2 A OR NOT B, 3 all ones. Y is chosen by func_sel[3:2]: 0 zero, 1 A AND NOT B, 2 A AND B, 3 A. The one exception is func_sel=15, where X=A and Y=0, so the result is A plus carry_in.
- R4: With logic_mode=0, carry_out is bit W of X + Y + carry_in. Consequences: code 9 with carry_in=1 gives A+B+1, code 6 with carry_in=1 gives A-B, and code 3 with carry_in=0 gives all ones.
- R5: With logic_mode=0, grp_gen is 1 exactly when X + Y >= 2^W, and grp_prop is 1 exactly when X + Y = 2^W - 1. As a result, carry_out equals grp_gen OR (grp_prop AND carry_in), and the two group bits are never both 1.
- R6: With logic_mode=1, grp_gen and grp_prop are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| func_sel | input | 4 | Function code |
| logic_mode | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in | input | 1 | Carry into bit 0, active high |
| result | output | W | Function result |
| carry_out | output | 1 | Carry out of the top bit |
| grp_gen | output | 1 | Slice generates a carry regardless of carry_in |
| grp_prop | output | 1 | Slice passes carry_in through to carry_out |

## Verification
The bench sweeps every operand pair under all 32 function codes, each with both carry-in values. This sweep hits the wrap-around points: all-ones plus one, A minus B with A < B, and the code-15 exception. An adder that dropped carry_in, or that let the carry chain leak into logic mode, shows up as a result off by one or a stray carry_out. A lookahead term with a wrong span would produce grp_gen or grp_prop values that disagree with the addend sum exactly at the boundaries where X + Y equals 2^W - 1 or 2^W. A mis-mapped table row gives a wrong result only for that one code, so every code gets its own full operand sweep.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  // First addend choice, indexed by func_sel[1:0]
  typedef enum logic [1:0] {
    XS_A     = 2'd0,
    XS_AORB  = 2'd1,
    XS_AORNB = 2'd2,
    XS_ONES  = 2'd3
  } xsel_e;

  // Second addend choice, indexed by func_sel[3:2]
  typedef enum logic [1:0] {
    YS_ZERO   = 2'd0,
    YS_AANDNB = 2'd1,
    YS_AANDB  = 2'd2,
    YS_A      = 2'd3
  } ysel_e;

  // Arithmetic code that overrides the regular X/Y split
  localparam logic [3:0] SEL_PASS_A = 4'hF;

  // Logic mode code points
  typedef enum logic [3:0] {
    LG_NOTA   = 4'd0,
    LG_NOR    = 4'd1,
    LG_NAANDB = 4'd2,
    LG_ZERO   = 4'd3,
    LG_NAND   = 4'd4,
    LG_NOTB   = 4'd5,
    LG_XOR    = 4'd6,
    LG_AANDNB = 4'd7,
    LG_NAORB  = 4'd8,
    LG_XNOR   = 4'd9,
    LG_B      = 4'd10,
    LG_AND    = 4'd11,
    LG_A      = 4'd12,
    LG_AORNB  = 4'd13,
    LG_OR     = 4'd14,
    LG_ONES   = 4'd15
  } lsel_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  output logic [W-1:0] x,
  output logic [W-1:0] y
);

  xsel_e xs;
  ysel_e ys;

  always_comb begin
    xs = xsel_e'(sel[1:0]);
    ys = ysel_e'(sel[3:2]);
    if (sel == SEL_PASS_A) begin
      xs = XS_A;
      ys = YS_ZERO;
    end
  end

  always_comb begin
    unique case (xs)
      XS_A:     x = a;
      XS_AORB:  x = a | b;
      XS_AORNB: x = a | ~b;
      default:  x = '1;
    endcase
  end

  always_comb begin
    unique case (ys)
      YS_ZERO:   y = '0;
      YS_AANDNB: y = a & ~b;
      YS_AANDB:  y = a & b;
      default:   y = a;
    endcase
  end

endmodule

// File: rtl/alu_cla.sv
module alu_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         gg,
  output logic         gp
);

  logic [W-1:0] g;
  logic [W-1:0] p;
  logic [W:0]   c;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      assign g[gi]   = x[gi] & y[gi];
      assign p[gi]   = x[gi] ^ y[gi];
      assign sum[gi] = p[gi] ^ c[gi];
    end
  endgenerate

  // Each carry is a flat sum of products of bit generates/propagates
  always_comb begin
    logic acc;
    logic span;
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        span = 1'b1;
        for (int k = j + 1; k <= i; k++) span = span & p[k];
        acc = acc | (g[j] & span);
      end
      span = cin;
      for (int k = 0; k <= i; k++) span = span & p[k];
      c[i+1] = acc | span;
    end
  end

  always_comb begin
    logic span;
    gg = 1'b0;
    for (int j = 0; j < W; j++) begin
      span = 1'b1;
      for (int k = j + 1; k < W; k++) span = span & p[k];
      gg = gg | (g[j] & span);
    end
  end

  assign gp   = &p;
  assign cout = c[W];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   sel,
  output logic [W-1:0] f
);

  always_comb begin
    unique case (lsel_e'(sel))
      LG_NOTA:   f = ~a;
      LG_NOR:    f = ~(a | b);
      LG_NAANDB: f = ~a & b;
      LG_ZERO:   f = '0;
      LG_NAND:   f = ~(a & b);
      LG_NOTB:   f = ~b;
      LG_XOR:    f = a ^ b;
      LG_AANDNB: f = a & ~b;
      LG_NAORB:  f = ~a | b;
      LG_XNOR:   f = ~(a ^ b);
      LG_B:      f = b;
      LG_AND:    f = a & b;
      LG_A:      f = a;
      LG_AORNB:  f = a | ~b;
      LG_OR:     f = a | b;
      default:   f = '1;
    endcase
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   func_sel,
  input  logic         logic_mode,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         grp_gen,
  output logic         grp_prop
);

  logic [W-1:0] add_x;
  logic [W-1:0] add_y;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_gg;
  logic         add_gp;
  logic [W-1:0] lgc_f;

  alu_operand_sel #(.W(W)) u_opsel (
    .a   (op_a),
    .b   (op_b),
    .sel (func_sel),
    .x   (add_x),
    .y   (add_y)
  );

  alu_cla #(.W(W)) u_cla (
    .x    (add_x),
    .y    (add_y),
    .cin  (carry_in),
    .sum  (add_sum),
    .cout (add_cout),
    .gg   (add_gg),
    .gp   (add_gp)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a   (op_a),
    .b   (op_b),
    .sel (func_sel),
    .f   (lgc_f)
  );

  assign result    = logic_mode ? lgc_f : add_sum;
  assign carry_out = ~logic_mode & add_cout;
  assign grp_gen   = ~logic_mode & add_gg;
  assign grp_prop  = ~logic_mode & add_gp;

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [3:0]   func_sel,
  input logic         logic_mode,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         grp_gen,
  input logic         grp_prop
);

  always_comb begin
    AST_LOGIC_NO_CARRY: assert (!logic_mode || !carry_out); // R2
    AST_LOGIC_GROUP_LOW: assert (!logic_mode || (!grp_gen && !grp_prop)); // R6
    AST_LOOKAHEAD_EQ: assert (logic_mode || (carry_out == (grp_gen | (grp_prop & carry_in)))); // R5
    AST_GROUP_EXCL: assert (!(grp_gen && grp_prop)); // R5
    AST_LOGIC_XOR: assert (!(logic_mode && func_sel == 4'd6) || (result == (op_a ^ op_b))); // R1
    AST_ADD_PLAIN: assert (logic_mode || func_sel != 4'd9 || carry_in || (result == W'(op_a + op_b))); // R3
  end

endmodule

bind alu_slice alu_slice_chk #(.W(W)) u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .func_sel   (func_sel),
  .logic_mode (logic_mode),
  .carry_in   (carry_in),
  .result     (result),
  .carry_out  (carry_out),
  .grp_gen    (grp_gen),
  .grp_prop   (grp_prop)
);

// File: tb/alu_slice_test.sv
module alu_slice_test;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   func_sel = '0;
  logic         logic_mode = 1'b0;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;
  logic         grp_gen;
  logic         grp_prop;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_slice #(.W(W)) uut (
    .op_a       (op_a),
    .op_b       (op_b),
    .func_sel   (func_sel),
    .logic_mode (logic_mode),
    .carry_in   (carry_in),
    .result     (result),
    .carry_out  (carry_out),
    .grp_gen    (grp_gen),
    .grp_prop   (grp_prop)
  );

  function automatic int addend_x(int a, int b, int s);
    if (s == 15) return a;
    case (s % 4)
      0: return a;
      1: return (a | b) & (M - 1);
      2: return (a | (~b)) & (M - 1);
      default: return M - 1;
    endcase
  endfunction

  function automatic int addend_y(int a, int b, int s);
    if (s == 15) return 0;
    case (s / 4)
      0: return 0;
      1: return a & (~b) & (M - 1);
      2: return a & b;
      default: return a;
    endcase
  endfunction

  function automatic int logic_ref(int a, int b, int s);
    int r;
    case (s)
      0: r = ~a;        1: r = ~(a | b);  2: r = (~a) & b;  3: r = 0;
      4: r = ~(a & b);  5: r = ~b;        6: r = a ^ b;     7: r = a & (~b);
      8: r = (~a) | b;  9: r = ~(a ^ b);  10: r = b;        11: r = a & b;
      12: r = a;        13: r = a | (~b); 14: r = a | b;    default: r = -1;
    endcase
    return r & (M - 1);
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (mode=%0d sel=%0d a=%0d b=%0d cin=%0d)",
               req, what, act, exp, logic_mode, func_sel, op_a, op_b, carry_in);
    end
  endtask

  task automatic apply(int a, int b, int s, bit m, bit ci);
    int x, y, tot;
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); func_sel = 4'(s); logic_mode = m; carry_in = ci;
    #1;
    vectors++;
    if (m) begin
      cmp("R1", "result", int'(result), logic_ref(a, b, s));
      cmp("R2", "carry_out", int'(carry_out), 0);
      cmp("R6", "grp_gen", int'(grp_gen), 0);
      cmp("R6", "grp_prop", int'(grp_prop), 0);
    end else begin
      x = addend_x(a, b, s);
      y = addend_y(a, b, s);
      tot = x + y + int'(ci);
      cmp("R3", "result", int'(result), tot % M);
      cmp("R4", "carry_out", int'(carry_out), tot / M);
      cmp("R5", "grp_gen", int'(grp_gen), (x + y >= M) ? 1 : 0);
      cmp("R5", "grp_prop", int'(grp_prop), (x + y == M - 1) ? 1 : 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // quiescent state: all inputs low gives A plus 0
    apply(0, 0, 0, 1'b0, 1'b0);
    // directed corners named in the requirements
    apply(7, 9, 9, 1'b0, 1'b1);      // R4: A+B+1 wraps to 1 with carry
    apply(3, 5, 6, 1'b0, 1'b1);      // R4: A-B borrow case
    apply(5, 3, 6, 1'b0, 1'b1);      // R4: A-B = 2 with carry
    apply(6, 2, 3, 1'b0, 1'b0);      // R4: all ones
    apply(15, 15, 15, 1'b0, 1'b1);   // R3: exception code
    apply(10, 5, 6, 1'b1, 1'b1);     // R2: carry_in ignored in logic mode
    apply(10, 5, 6, 1'b1, 1'b0);     // R2
    apply(15, 0, 9, 1'b0, 1'b1);     // R5: propagate through
    // exhaustive sweep of every code, mode and carry
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int ci = 0; ci < 2; ci++)
          for (int a = 0; a < M; a++)
            for (int b = 0; b < M; b++)
              apply(a, b, s, m[0], ci[0]);
    // random mix
    for (int n = 0; n < 500; n++)
      apply(int'($urandom % M), int'($urandom % M), int'($urandom % 16),
            1'($urandom), 1'($urandom));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule